// File: doc/BRIEF.md
# Paged Serial Flash Program Engine

This block programs a byte stream of any length into a serial NOR flash through a four-wire SPI link (mode 0, most significant bit first). A request carries a start address and a total byte count. The engine cuts the transfer into chunks that each stay inside one flash page. For every chunk it sends a write-enable frame, waits a settling gap with chip select high, and sends one program frame. That frame holds the program opcode, the address bytes, and the chunk's data bytes taken from a valid/ready input stream. The engine then reads the status byte at a fixed interval until the busy bit clears.

Once a chunk completes, the address moves forward and the remaining count shrinks by the chunk size. The next chunk starts after a short rest. When the count reaches zero the engine pulses `done` with `error` low. If the busy bit stays set for the whole poll budget, the engine drops the rest of the request and pulses `done` with `error` high. Time intervals and the poll budget are counted in system clock cycles. This lets the integrator map them to microseconds for the clock in use.

Top module: `flash_page_writer`

## Requirements
- R1: A chunk never crosses a page boundary. The first chunk length is the smaller of the remaining count and PAGE_BYTES minus (address mod PAGE_BYTES). Each later chunk is the smaller of the remaining count and PAGE_BYTES.
- R2: No program frame carries more than PAGE_BYTES data bytes. A page-aligned request of exactly PAGE_BYTES bytes is sent in a single frame.
- R3: Each chunk begins with a frame holding only the byte 0x06. Chip select then stays high for at least GAP_CYC clock cycles before the program frame.
- R4: The program frame is one chip-select frame. It carries 0x02, then the ADDR_W/8 address bytes most significant first, then the data bytes in stream order. Bits go out MSB first on spi_mosi in SPI mode 0, and spi_sck stays low while spi_csn is high.
- R5: After a program frame, each status frame is two bytes: 0x05 followed by one byte read from spi_miso. Each status frame starts at least POLL_CYC cycles after the previous frame ends. Polling repeats while bit BUSY_BIT (default bit 0) of the read byte is 1.
- R6: When a status byte shows ready, the address advances by the chunk length and the remaining count drops by it. The next chunk follows while the count is non-zero. No frame is sent after the final chunk's ready status.
- R7: If MAX_POLLS status reads after one chunk all show busy, the write is aborted. `done` pulses with `error` = 1, no further frame is sent, and the unsent stream bytes are not consumed.
- R8: `s_ready` is high only inside a program frame, between data bytes. Exactly the total requested count of bytes is taken from the stream for a completed write.
- R9: `done` is a one-cycle pulse. `error` is valid while `done` is high and is 0 for a successful write. `req_ready` is high only while idle. A request with length 0 pulses `done` with no frame.
- R10: After reset, spi_csn is high, spi_sck is low, req_ready is high, and done and s_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a write with req_addr and req_len |
| req_ready | output | 1 | Engine idle and accepting a request |
| req_addr | input | ADDR_W | Flash byte address of the first byte |
| req_len | input | LEN_W | Number of bytes to program |
| s_valid | input | 1 | Stream byte available |
| s_ready | output | 1 | Engine takes the stream byte this cycle |
| s_data | input | 8 | Stream byte |
| done | output | 1 | One-cycle end-of-write pulse |
| error | output | 1 | Write aborted on status timeout (valid with done) |
| spi_sck | output | 1 | SPI serial clock, idle low |
| spi_csn | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The bench builds the engine with PAGE_BYTES = 16, SCK_HALF = 2, GAP_CYC = 6, POLL_CYC = 10, MAX_POLLS = 4 and LEN_W = 16. With a 16-byte page, a 40-byte request splits into a short head chunk, two full pages and a tail, in a few thousand cycles. An 18-byte request starting one byte before a boundary produces one-byte chunks on both sides of a full page. The small poll budget lets a flash model that stays busy drive the abort path in a handful of status frames. The short gap and poll intervals keep every run's spacing measurable.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WEN,
      ST_GAP,
      ST_PCMD,
      ST_PDATA,
      ST_PWAIT,
      ST_SCMD,
      ST_REST,
      ST_FIN
   } fpw_state_e;

   localparam logic [7:0] OP_WEN  = 8'h06;
   localparam logic [7:0] OP_PROG = 8'h02;
   localparam logic [7:0] OP_STAT = 8'h05;

endpackage

// File: rtl/fpw_shift.sv
// One-byte SPI mode-0 shifter: drives MSB first, samples on the rising edge.
module fpw_shift #(
   parameter int SCK_HALF = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx,
   output logic       busy,
   output logic       done,
   output logic [7:0] rx,
   output logic       sck,
   output logic       mosi,
   input  logic       miso
);
   localparam int DW = $clog2(SCK_HALF + 1);

   logic [DW-1:0] div_q;
   logic [2:0]    bit_q;
   logic [7:0]    sr_q;
   logic [7:0]    rx_q;
   logic          sck_q;
   logic          act_q;
   logic          done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         bit_q  <= '0;
         sr_q   <= '0;
         rx_q   <= '0;
         sck_q  <= 1'b0;
         act_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            sr_q  <= tx;
            bit_q <= '0;
            div_q <= '0;
            sck_q <= 1'b0;
            act_q <= 1'b1;
         end else if (act_q) begin
            if (div_q == DW'(SCK_HALF - 1)) begin
               div_q <= '0;
               if (!sck_q) begin
                  sck_q <= 1'b1;
                  rx_q  <= {rx_q[6:0], miso};
               end else begin
                  sck_q <= 1'b0;
                  sr_q  <= {sr_q[6:0], 1'b0};
                  if (bit_q == 3'd7) begin
                     act_q  <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     bit_q <= bit_q + 3'd1;
                  end
               end
            end else begin
               div_q <= div_q + DW'(1);
            end
         end
      end
   end

   assign busy = act_q;
   assign done = done_q;
   assign rx   = rx_q;
   assign sck  = sck_q;
   assign mosi = act_q & sr_q[7];

   // R4: a new byte is never loaded over one still on the wire
   p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !act_q);

   // R4: the clock toggles only while a byte is in flight
   p_sck_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !act_q |=> !sck_q);

endmodule

// File: rtl/fpw_chunk.sv
// Bytes that fit before the next page boundary, capped by what remains.
module fpw_chunk #(
   parameter int PAGE_BYTES = 256,
   parameter int LEN_W      = 24
) (
   input  logic [$clog2(PAGE_BYTES)-1:0] off,
   input  logic [LEN_W-1:0]              rem,
   output logic [$clog2(PAGE_BYTES):0]   len
);
   localparam int CH_W = $clog2(PAGE_BYTES) + 1;

   logic [CH_W-1:0] room;

   assign room = CH_W'(PAGE_BYTES) - CH_W'(off);

   generate
      if (LEN_W > CH_W) begin : g_wide
         assign len = (rem < LEN_W'(room)) ? CH_W'(rem) : room;
      end else begin : g_narrow
         assign len = (CH_W'(rem) < room) ? CH_W'(rem) : room;
      end
   endgenerate

endmodule

// File: rtl/fpw_wait.sv
// Cycle counter for chip-select-high intervals; cleared whenever not running.
module fpw_wait #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         hit
);
   logic [W-1:0] cnt_q;

   assign hit = run && (cnt_q == limit - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (!hit)   cnt_q <= cnt_q + W'(1);
   end

   // R3: the interval ends exactly at its limit, never runs past it
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < limit));

endmodule

// File: rtl/flash_page_writer.sv
module flash_page_writer
   import fpw_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int LEN_W      = 24,
   parameter int PAGE_BYTES = 256,
   parameter int SCK_HALF   = 2,
   parameter int GAP_CYC    = 500,
   parameter int POLL_CYC   = 50000,
   parameter int MAX_POLLS  = 1000,
   parameter int BUSY_BIT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [7:0]        s_data,
   output logic              done,
   output logic              error,
   output logic              spi_sck,
   output logic              spi_csn,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   localparam int ADDR_BYTES = ADDR_W / 8;
   localparam int PG_BITS    = $clog2(PAGE_BYTES);
   localparam int CH_W       = PG_BITS + 1;
   localparam int WAIT_MAX   = (POLL_CYC > GAP_CYC) ? POLL_CYC : GAP_CYC;
   localparam int WT_W       = $clog2(WAIT_MAX + 1);
   localparam int PL_W       = $clog2(MAX_POLLS + 1);
   localparam logic [7:0] BUSY_MASK = 8'(1 << BUSY_BIT);

   generate
      if (ADDR_W % 8 != 0 || ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must be 8, 16, 24 or 32");
      end
      if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two of at least 2");
      end
      if (LEN_W < CH_W) begin : g_bad_len
         $error("LEN_W must hold one full page count");
      end
      if (GAP_CYC < 1 || POLL_CYC < 1 || MAX_POLLS < 1 || SCK_HALF < 1) begin : g_bad_time
         $error("intervals, divider and poll budget must be at least 1");
      end
      if (BUSY_BIT < 0 || BUSY_BIT > 7) begin : g_bad_bit
         $error("BUSY_BIT must index the status byte");
      end
   endgenerate

   fpw_state_e        st;
   logic              pend_q;
   logic [2:0]        idx_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  rem_q;
   logic [CH_W-1:0]   clen_q;
   logic [CH_W-1:0]   cleft_q;
   logic [PL_W-1:0]   polls_q;
   logic              err_q;

   logic              sh_start, sh_busy, sh_done;
   logic [7:0]        sh_tx, sh_rx;
   logic [CH_W-1:0]   chunk_w;
   logic              wait_run, wait_hit;
   logic [WT_W-1:0]   wait_lim;
   logic              in_frame;
   logic [7:0]        cmd_byte;
   logic [31:0]       addr_al, addr_sh;
   logic [2:0]        aix;
   logic              stat_busy;

   // ---------------- submodules ----------------
   fpw_shift #(.SCK_HALF(SCK_HALF)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .start (sh_start),
      .tx    (sh_tx),
      .busy  (sh_busy),
      .done  (sh_done),
      .rx    (sh_rx),
      .sck   (spi_sck),
      .mosi  (spi_mosi),
      .miso  (spi_miso)
   );

   fpw_chunk #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W)) u_chunk (
      .off (addr_q[PG_BITS-1:0]),
      .rem (rem_q),
      .len (chunk_w)
   );

   fpw_wait #(.W(WT_W)) u_wait (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (wait_run),
      .limit (wait_lim),
      .hit   (wait_hit)
   );

   // ---------------- decode ----------------
   assign in_frame  = (st == ST_WEN) || (st == ST_PCMD) || (st == ST_PDATA) || (st == ST_SCMD);
   assign spi_csn   = !in_frame;
   assign req_ready = (st == ST_IDLE);
   assign done      = (st == ST_FIN);
   assign error     = err_q;
   assign s_ready   = (st == ST_PDATA) && !sh_busy && !sh_done && (cleft_q != '0);

   assign wait_run  = (st == ST_GAP) || (st == ST_PWAIT) || (st == ST_REST);
   assign wait_lim  = (st == ST_PWAIT) ? WT_W'(POLL_CYC) : WT_W'(GAP_CYC);

   assign stat_busy = |(sh_rx & BUSY_MASK);

   // address bytes, most significant first, picked by shifting a left-aligned copy
   assign addr_al = 32'(addr_q) << (32 - ADDR_W);
   assign aix     = idx_q - 3'd1;
   assign addr_sh = addr_al << {aix, 3'b000};

   always_comb begin
      case (st)
         ST_WEN:  cmd_byte = OP_WEN;
         ST_PCMD: cmd_byte = (idx_q == 3'd0) ? OP_PROG : addr_sh[31:24];
         ST_SCMD: cmd_byte = (idx_q == 3'd0) ? OP_STAT : 8'h00;
         default: cmd_byte = 8'h00;
      endcase
   end

   assign sh_start = pend_q || (s_valid && s_ready);
   assign sh_tx    = (st == ST_PDATA) ? s_data : cmd_byte;

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         pend_q  <= 1'b0;
         idx_q   <= '0;
         addr_q  <= '0;
         rem_q   <= '0;
         clen_q  <= '0;
         cleft_q <= '0;
         polls_q <= '0;
         err_q   <= 1'b0;
      end else begin
         pend_q <= 1'b0;
         case (st)
            ST_IDLE: if (req_valid) begin
               addr_q <= req_addr;
               rem_q  <= req_len;
               err_q  <= 1'b0;
               if (req_len == '0) begin
                  st <= ST_FIN;
               end else begin
                  st     <= ST_WEN;
                  pend_q <= 1'b1;
                  idx_q  <= '0;
               end
            end
            ST_WEN: if (sh_done) st <= ST_GAP;
            ST_GAP: if (wait_hit) begin
               st      <= ST_PCMD;
               pend_q  <= 1'b1;
               idx_q   <= '0;
               clen_q  <= chunk_w;
               cleft_q <= chunk_w;
               polls_q <= '0;
            end
            ST_PCMD: if (sh_done) begin
               if (idx_q == 3'(ADDR_BYTES)) begin
                  st <= ST_PDATA;
               end else begin
                  idx_q  <= idx_q + 3'd1;
                  pend_q <= 1'b1;
               end
            end
            ST_PDATA: if (sh_done) begin
               cleft_q <= cleft_q - CH_W'(1);
               if (cleft_q == CH_W'(1)) st <= ST_PWAIT;
            end
            ST_PWAIT: if (wait_hit) begin
               st     <= ST_SCMD;
               pend_q <= 1'b1;
               idx_q  <= '0;
            end
            ST_SCMD: if (sh_done) begin
               if (idx_q == 3'd0) begin
                  idx_q  <= 3'd1;
                  pend_q <= 1'b1;
               end else if (stat_busy) begin
                  if (polls_q == PL_W'(MAX_POLLS - 1)) begin
                     err_q <= 1'b1;
                     st    <= ST_FIN;
                  end else begin
                     polls_q <= polls_q + PL_W'(1);
                     st      <= ST_PWAIT;
                  end
               end else begin
                  addr_q <= addr_q + ADDR_W'(clen_q);
                  rem_q  <= rem_q - LEN_W'(clen_q);
                  if (rem_q == LEN_W'(clen_q)) st <= ST_FIN;
                  else                         st <= ST_REST;
               end
            end
            ST_REST: if (wait_hit) begin
               st     <= ST_WEN;
               pend_q <= 1'b1;
               idx_q  <= '0;
            end
            ST_FIN:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // ---------------- assertions ----------------
   // R1: the loaded chunk ends on or before the page boundary
   p_no_cross_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PCMD) |-> ((CH_W + 1)'(addr_q[PG_BITS-1:0]) + (CH_W + 1)'(clen_q)
                           <= (CH_W + 1)'(PAGE_BYTES)));

   // R2: a program frame never exceeds one page and is never empty
   p_chunk_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PDATA) |-> (clen_q != '0 && clen_q <= CH_W'(PAGE_BYTES) && cleft_q <= clen_q));

   // R4: serial clock rests low outside a frame
   p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      spi_csn |-> !spi_sck);

   // R7: the error flag is raised only together with the end pulse
   p_err_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> done);

   // R8: stream bytes are taken only inside a program frame
   p_ready_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (!spi_csn && !sh_busy));

   // R9: done lasts a single cycle
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: tb/flash_page_writer_bench.sv
module flash_page_writer_bench;
   localparam int AW   = 24;
   localparam int LW   = 16;
   localparam int PG   = 16;
   localparam int HALF = 2;
   localparam int GAP  = 6;
   localparam int POLL = 10;
   localparam int MAXP = 4;
   localparam int NFR  = 128;
   localparam int NBY  = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic          s_valid = 1'b0;
   logic          s_ready;
   logic [7:0]    s_data = 8'h00;
   logic          done, error;
   logic          spi_sck, spi_csn, spi_mosi, spi_miso;

   always #5 clk = ~clk;

   flash_page_writer #(
      .ADDR_W(AW), .LEN_W(LW), .PAGE_BYTES(PG), .SCK_HALF(HALF),
      .GAP_CYC(GAP), .POLL_CYC(POLL), .MAX_POLLS(MAXP), .BUSY_BIT(0)
   ) u_flash_page_writer (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len),
      .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
      .done(done), .error(error),
      .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   bit finished = 0;

   always @(negedge clk) cyc++;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int k);
      return 8'(k * 37 + 11);
   endfunction

   // ---------------- flash model: frame capture and status replies ----------------
   int         nfr = 0;
   int         flen [NFR];
   logic [7:0] fb [NFR][NBY];
   int         t0 [NFR];
   int         t1 [NFR];
   int         bitc = 0;
   logic [7:0] shreg = 8'h00;
   logic       csn_prev = 1'b1;
   logic       sck_prev = 1'b0;
   logic       stat_now = 1'b0;
   logic [7:0] stat_val = 8'h00;
   int         busy_cfg = 0;
   int         busy_left = 0;

   assign spi_miso = (stat_now && !spi_csn) ? stat_val[3'(7 - bitc)] : 1'b0;

   always @(spi_csn or spi_sck) begin
      if (spi_csn === 1'b0 && csn_prev === 1'b1) begin
         if (nfr < NFR) begin
            flen[nfr] = 0;
            t0[nfr] = cyc;
         end
         stat_now = 1'b0;
         bitc = 0;
      end else if (spi_csn === 1'b1 && csn_prev === 1'b0) begin
         if (nfr < NFR) t1[nfr] = cyc;
         nfr++;
         stat_now = 1'b0;
      end
      csn_prev = spi_csn;
      if (spi_sck === 1'b1 && sck_prev !== 1'b1 && spi_csn === 1'b0) begin
         shreg = {shreg[6:0], spi_mosi};
         bitc++;
         if (bitc == 8) begin
            bitc = 0;
            if (nfr < NFR) begin
               if (flen[nfr] < NBY) fb[nfr][flen[nfr]] = shreg;
               flen[nfr]++;
               if (flen[nfr] == 1 && shreg == 8'h02) busy_left = busy_cfg;
               if (flen[nfr] == 1 && shreg == 8'h05) begin
                  stat_now = 1'b1;
                  if (busy_left > 0) begin
                     stat_val = 8'h01;
                     busy_left--;
                  end else begin
                     stat_val = 8'hFE;
                  end
               end
            end
         end
      end
      sck_prev = spi_sck;
   end

   // ---------------- stream source ----------------
   bit feed_on = 0;
   bit stall_mode = 0;
   int taken = 0;
   bit took = 0;
   int rdy_bad = 0;

   always @(negedge clk) begin
      logic v;
      if (took) taken++;
      v = feed_on && (!stall_mode || (cyc % 3 != 1));
      s_valid = v;
      s_data  = pat(taken);
      took    = v && (s_ready === 1'b1);
      if (s_ready === 1'b1 && spi_csn === 1'b1) rdy_bad++;
   end

   // ---------------- one write plus full frame check ----------------
   task automatic run_write(input logic [AW-1:0] a0, input int len, input int busy,
                            input bit stall, input bit exp_err, input string tag);
      int fbase, tbase, f, a, r, k, c, npoll, bad, nfr_done, rb0;
      bit got, errv;
      busy_cfg   = busy;
      stall_mode = stall;
      fbase = nfr;
      tbase = taken;
      rb0   = rdy_bad;
      @(negedge clk);
      chk(req_ready == 1'b1, {tag, " R9 req_ready idle"}, req_ready, 1);
      req_valid = 1'b1;
      req_addr  = a0;
      req_len   = LW'(len);
      feed_on   = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, {tag, " R9 req_ready busy"}, req_ready, 0);
      got = 0;
      for (int i = 0; i < 40000; i++) begin
         if (done) begin
            got = 1;
            break;
         end
         @(negedge clk);
      end
      errv = error;
      nfr_done = nfr;
      chk(got, {tag, " R9 done seen"}, got, 1);
      chk(errv == exp_err, {tag, " R7 R9 error flag"}, errv, exp_err);
      @(negedge clk);
      chk(done == 1'b0, {tag, " R9 done one cycle"}, done, 0);
      chk(req_ready == 1'b1, {tag, " R9 idle after done"}, req_ready, 1);
      feed_on = 1'b0;
      repeat (60) @(negedge clk);
      chk(nfr == nfr_done, {tag, " R6 R7 no frame after done"}, nfr - nfr_done, 0);
      chk(rdy_bad == rb0, {tag, " R8 s_ready outside frame"}, rdy_bad - rb0, 0);

      f = fbase; a = int'(a0); r = len; k = 0;
      while (r > 0) begin
         c = PG - (a % PG);
         if (r < c) c = r;
         chk(flen[f] == 1 && fb[f][0] == 8'h06, {tag, " R3 write-enable frame"}, fb[f][0], 6);
         chk(t0[f+1] - t1[f] >= GAP, {tag, " R3 gap after write-enable"}, t0[f+1] - t1[f], GAP);
         chk(flen[f+1] == 4 + c, {tag, " R1 R2 program frame length"}, flen[f+1], 4 + c);
         bad = 0;
         if (fb[f+1][0] != 8'h02) bad++;
         if (fb[f+1][1] != 8'(a >> 16)) bad++;
         if (fb[f+1][2] != 8'(a >> 8)) bad++;
         if (fb[f+1][3] != 8'(a)) bad++;
         for (int j = 0; j < c && j + 4 < NBY; j++)
            if (fb[f+1][4+j] != pat(tbase + k + j)) bad++;
         chk(bad == 0, {tag, " R4 program frame content"}, bad, 0);
         f += 2;
         npoll = exp_err ? MAXP : busy + 1;
         for (int p = 0; p < npoll; p++) begin
            chk(flen[f] == 2 && fb[f][0] == 8'h05, {tag, " R5 status frame"}, fb[f][0], 5);
            chk(t0[f] - t1[f-1] >= POLL, {tag, " R5 poll spacing"}, t0[f] - t1[f-1], POLL);
            f++;
         end
         k += c;
         if (exp_err) break;
         a += c;
         r -= c;
      end
      chk(nfr - fbase == f - fbase, {tag, " R6 frame count"}, nfr - fbase, f - fbase);
      chk(taken - tbase == k, {tag, " R8 bytes consumed"}, taken - tbase, k);
   endtask

   task automatic t_reset();
      chk(spi_csn == 1'b1, "R10 csn high", spi_csn, 1);
      chk(spi_sck == 1'b0, "R10 sck low", spi_sck, 0);
      chk(req_ready == 1'b1, "R10 req_ready", req_ready, 1);
      chk(done == 1'b0 && s_ready == 1'b0, "R10 done/s_ready low", done, 0);
   endtask

   task automatic t_single();   // inside one page
      run_write(24'h000123, 5, 0, 0, 0, "single");
   endtask

   task automatic t_cross();    // R1: 6 + 16 + 16 + 2
      run_write(24'h00013A, 40, 1, 0, 0, "cross");
   endtask

   task automatic t_zero();     // R9: empty request
      int fb0 = nfr;
      run_write(24'h000777, 0, 0, 0, 0, "zero");
      chk(nfr == fb0, "R9 zero length sends nothing", nfr - fb0, 0);
   endtask

   task automatic t_stall();    // R8 + R4 upper address byte: 1 + 16 + 1
      run_write(24'hABCDEF, 18, 2, 1, 0, "stall");
   endtask

   task automatic t_timeout();  // R7: first chunk never finishes
      run_write(24'h000005, 20, 100, 0, 1, "timeout");
   endtask

   task automatic t_full_page(); // R2: aligned full page in one frame
      run_write(24'h000200, 16, 0, 0, 0, "fullpage");
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_cross();
      t_zero();
      t_stall();
      t_timeout();
      t_full_page();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      finish_run();
   end

endmodule